// File: doc/BRIEF.md
# Digit-Serial Binary Field Multiply/Add Unit

This unit does arithmetic in the binary polynomial field of degree 163. The field is reduced by P(x) = x^163 + x^7 + x^6 + x^3 + 1. One array of XOR cells does two jobs. It multiplies two field elements, or it adds an operand into the accumulator. A squaring is a multiply with the same value on both operand inputs. It is meant to be the arithmetic core of a small elliptic-curve point engine, where register area is the main cost.

A multiply absorbs operand A one digit of `DIGIT` bits per cycle, most significant digit first. Operand B is applied to all cells in parallel. The result builds up in the accumulator C. The A register rotates left by one digit each cycle. On the final cycle it rotates by the leftover width instead, so A is back at its loaded value when the multiply ends. An add takes one cycle. Only C changes as a result of an operation.

Top module: `gf2m_digit_alu`

## Requirements
- R1: With `op_mul`=1, the value on `acc_out` when `done` is high equals A·B mod P(x). Here A and B are the `opa_in` and `opb_in` values sampled with `start`, bit i is the coefficient of x^i, and P(x) = x^163 + x^7 + x^6 + x^3 + 1. The `acc_in` value has no effect on this result.
- R2: With `op_mul`=0, an accepted `start` writes `opb_in` XOR `acc_in` into `acc_out`, and `done` is high in the very next cycle.
- R3: For a multiply accepted at clock edge k, `done` is high during the cycle that follows edge k + ceil(163/DIGIT). With the default DIGIT=4, that is edge k+41.
- R4: When `opa_in` equals `opb_in`, the multiply returns the square of that operand.
- R5: `opa_out` shows the A register. At every `done`, and at all times while the unit is idle, it equals the `opa_in` value last accepted.
- R6: While no operation is running, `acc_out` holds its last result.
- R7: A `start` that arrives while a multiply is running is ignored. The running multiply's result, its `done` timing and `opa_out` are unchanged.
- R8: `done` lasts one cycle and is never high while a multiply is running. A `start` given in the `done` cycle is accepted.
- R9: After synchronous reset (`rst_n`=0), `acc_out` and `opa_out` are zero and `done` is low.
- R10: When 163 is not a multiple of DIGIT, the final cycle absorbs only the 163 mod DIGIT lowest bits of A. For example, A = 1 gives C = B.
- R11: Overflow past x^162 is folded back through P(x). For example, x^162 · x gives x^7 + x^6 + x^3 + 1 (value 0xC9).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_mul | input | 1 | 1 = multiply/square, 0 = add |
| opa_in | input | 163 | Operand A, loaded at start |
| opb_in | input | 163 | Operand B, loaded at start |
| acc_in | input | 163 | Initial accumulator for an add |
| acc_out | output | 163 | Accumulator C |
| opa_out | output | 163 | Current contents of the A register |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two kinds of event can land in the same cycle. In the first, a multiply ends (its `done` pulse) and a new `start` is accepted. The bench provokes this by raising `start` in the very cycle it sees `done`. It then expects the second operation's result at the exact cycle the reference model predicts. In the second, a `start` with different operands and command is pulsed halfway through a multiply, while A is rotating. Here the model keeps the original product, the original completion cycle and the original A. Any leak of the stray request shows up as a mismatch in `acc_out`, `done` or `opa_out`.

// File: rtl/gf2m_pkg.sv
// Package gf2m_pkg
// Shared defaults and the command encoding for the binary field unit.
// Assumes a trinomial/pentanomial reduction whose low part fits in the field width.
package gf2m_pkg;
    localparam int unsigned FIELD_W_DEF = 163;
    localparam int unsigned DIGIT_DEF   = 4;
    // low terms of the reduction polynomial: x^7 + x^6 + x^3 + 1
    localparam logic [7:0]  RED_LOW_DEF = 8'hC9;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } alu_op_e;
endpackage

// File: rtl/gf2m_mac_cell.sv
// Module gf2m_mac_cell
// One Horner step of a bit-serial field multiply: out = c*x + a_bit*b mod P.
// Purely combinational. Assumes RED_LOW holds P(x) minus its leading term.
module gf2m_mac_cell #(
    parameter int unsigned FIELD_W = 163,
    parameter logic [FIELD_W-1:0] RED_LOW = FIELD_W'(8'hC9)
) (
    input  logic [FIELD_W-1:0] c_in,
    input  logic               a_bit,
    input  logic [FIELD_W-1:0] b_in,
    output logic [FIELD_W-1:0] c_out
);
    logic [FIELD_W-1:0] shifted;

    // multiply by x and fold the overflow bit back through P
    always_comb begin
        shifted = {c_in[FIELD_W-2:0], 1'b0} ^ (c_in[FIELD_W-1] ? RED_LOW : '0);
        c_out   = shifted ^ (a_bit ? b_in : '0);
    end
endmodule

// File: rtl/gf2m_digit_array.sv
// Module gf2m_digit_array
// Chains DIGIT mac cells so a whole digit of A (msb first) is absorbed per cycle.
// On the last cycle only LAST_W cells count: the chain is tapped early.
module gf2m_digit_array #(
    parameter int unsigned FIELD_W = 163,
    parameter int unsigned DIGIT   = 4,
    parameter int unsigned LAST_W  = 3,
    parameter logic [FIELD_W-1:0] RED_LOW = FIELD_W'(8'hC9)
) (
    input  logic [FIELD_W-1:0] c_in,
    input  logic [DIGIT-1:0]   digit,
    input  logic [FIELD_W-1:0] b_in,
    input  logic               last,
    output logic [FIELD_W-1:0] c_next
);
    logic [FIELD_W-1:0] stage [DIGIT+1];

    assign stage[0] = c_in;

    for (genvar k = 0; k < DIGIT; k++) begin : g_cell
        gf2m_mac_cell #(.FIELD_W(FIELD_W), .RED_LOW(RED_LOW)) u_cell (
            .c_in (stage[k]),
            .a_bit(digit[DIGIT-1-k]),
            .b_in (b_in),
            .c_out(stage[k+1])
        );
    end

    if (LAST_W == DIGIT) begin : g_full
        // every digit is complete: one tap serves all cycles
        assign c_next = stage[DIGIT];
        logic unused_last;
        assign unused_last = last;
    end else begin : g_part
        // final digit is partial: take the tap after LAST_W cells
        assign c_next = last ? stage[LAST_W] : stage[DIGIT];
    end
endmodule

// File: rtl/gf2m_rot_reg.sv
// Module gf2m_rot_reg
// Operand A register. Loads on request, rotates left by DIGIT per step,
// or by LAST_W on the final step, so a full pass restores the loaded value.
module gf2m_rot_reg #(
    parameter int unsigned FIELD_W = 163,
    parameter int unsigned DIGIT   = 4,
    parameter int unsigned LAST_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_val,
    input  logic               rot,
    input  logic               last,
    output logic [FIELD_W-1:0] q
);
    logic [FIELD_W-1:0] rot_full;
    logic [FIELD_W-1:0] rot_next;

    assign rot_full = {q[FIELD_W-1-DIGIT:0], q[FIELD_W-1 -: DIGIT]};

    if (LAST_W == DIGIT) begin : g_even
        // no partial digit: a single rotation amount
        assign rot_next = rot_full;
        logic unused_last;
        assign unused_last = last;
    end else begin : g_odd
        // partial final digit: shorter closing rotation
        logic [FIELD_W-1:0] rot_part;
        assign rot_part = {q[FIELD_W-1-LAST_W:0], q[FIELD_W-1 -: LAST_W]};
        assign rot_next = last ? rot_part : rot_full;
    end

    // hold, load or rotate the operand
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (rot)  q <= rot_next;
    end
endmodule

// File: rtl/gf2m_digit_alu.sv
// Module gf2m_digit_alu
// Digit-serial multiply / add unit over GF(2^FIELD_W).
// Multiply: ceil(FIELD_W/DIGIT) cycles, accumulator cleared at start.
// Add: one cycle, acc = B ^ acc_in. A start while busy is dropped.
module gf2m_digit_alu
    import gf2m_pkg::*;
#(
    parameter int unsigned FIELD_W = FIELD_W_DEF,
    parameter int unsigned DIGIT   = DIGIT_DEF,
    parameter logic [FIELD_W-1:0] RED_LOW = FIELD_W'(RED_LOW_DEF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               op_mul,
    input  logic [FIELD_W-1:0] opa_in,
    input  logic [FIELD_W-1:0] opb_in,
    input  logic [FIELD_W-1:0] acc_in,
    output logic [FIELD_W-1:0] acc_out,
    output logic [FIELD_W-1:0] opa_out,
    output logic               done
);
    localparam int unsigned NDIG   = (FIELD_W + DIGIT - 1) / DIGIT;
    localparam int unsigned LAST_W = FIELD_W - (NDIG - 1) * DIGIT;
    localparam int unsigned CNT_W  = $clog2(NDIG + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NDIG - 1);

    logic               busy;
    logic [CNT_W-1:0]   cnt;
    logic [FIELD_W-1:0] b_q;
    logic [FIELD_W-1:0] c_q;
    logic [FIELD_W-1:0] c_step;
    logic               accept;
    logic               last;
    alu_op_e            op;

    assign op      = alu_op_e'(op_mul);
    assign accept  = start && !busy;
    assign last    = busy && (cnt == LAST_CNT);
    assign acc_out = c_q;

    gf2m_rot_reg #(.FIELD_W(FIELD_W), .DIGIT(DIGIT), .LAST_W(LAST_W)) u_areg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(opa_in),
        .rot     (busy),
        .last    (last),
        .q       (opa_out)
    );

    gf2m_digit_array #(.FIELD_W(FIELD_W), .DIGIT(DIGIT), .LAST_W(LAST_W),
                       .RED_LOW(RED_LOW)) u_cells (
        .c_in  (c_q),
        .digit (opa_out[FIELD_W-1 -: DIGIT]),
        .b_in  (b_q),
        .last  (last),
        .c_next(c_step)
    );

    // sequencing: busy flag, digit counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                cnt <= cnt + 1'b1;
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (accept) begin
                cnt <= '0;
                if (op == OP_MUL) busy <= 1'b1;
                else              done <= 1'b1;
            end
        end
    end

    // operand B register: loaded on accept only
    always_ff @(posedge clk) begin
        if (!rst_n)      b_q <= '0;
        else if (accept) b_q <= opb_in;
    end

    // accumulator: clear or add on accept, Horner step while busy
    always_ff @(posedge clk) begin
        if (!rst_n)           c_q <= '0;
        else if (busy)        c_q <= c_step;
        else if (accept)      c_q <= (op == OP_MUL) ? '0 : (opb_in ^ acc_in);
    end

    // ---------------- assertions ----------------
    logic [FIELD_W-1:0] a_snap;
    logic [CNT_W:0]     chk_cnt;
    logic               chk_mul;

    // checker state: operand snapshot and independent busy-cycle count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_snap  <= '0;
            chk_cnt <= '0;
            chk_mul <= 1'b0;
        end else if (accept) begin
            a_snap  <= opa_in;
            chk_cnt <= '0;
            chk_mul <= op_mul;
        end else if (busy) begin
            chk_cnt <= chk_cnt + 1'b1;
        end
    end

    // R5
    a_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> opa_out == a_snap);

    // R3
    mul_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chk_mul) |-> chk_cnt == (CNT_W+1)'(NDIG));

    // R2
    add_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !op_mul) |=> done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(b_q));

    // R6
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !done) |=> $stable(acc_out));
endmodule

// File: tb/tb_gf2m_digit_alu.sv
module tb_gf2m_digit_alu;
    localparam int CLK_PERIOD = 10;
    localparam int FW   = 163;
    localparam int DG   = 4;
    localparam int NDIG = (FW + DG - 1) / DG;
    localparam int WDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          cmd_i = 1'b0;
    logic [FW-1:0] a_i = '0, b_i = '0, c_i = '0;
    logic [FW-1:0] acc_o, opa_o;
    logic          done_o;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    string cur_tag = "R1";

    // reference model state
    logic          m_busy = 1'b0;
    logic          m_done = 1'b0;
    int            m_left = 0;
    logic [FW-1:0] m_c = '0, m_a = '0, m_pend = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gf2m_digit_alu #(.FIELD_W(FW), .DIGIT(DG)) dut (
        .clk(clk), .rst_n(rst_n), .start(start_i), .op_mul(cmd_i),
        .opa_in(a_i), .opb_in(b_i), .acc_in(c_i),
        .acc_out(acc_o), .opa_out(opa_o), .done(done_o)
    );

    // schoolbook product then reduction by x^163 = x^7+x^6+x^3+1
    function automatic logic [FW-1:0] ref_mul(input logic [FW-1:0] a, input logic [FW-1:0] b);
        logic [2*FW-2:0] p = '0;
        for (int i = 0; i < FW; i++)
            if (a[i]) for (int j = 0; j < FW; j++) p[i+j] ^= b[j];
        for (int i = 2*FW-2; i >= FW; i--)
            if (p[i]) begin
                p[i] = 1'b0;
                p[i-FW+7] ^= 1'b1;
                p[i-FW+6] ^= 1'b1;
                p[i-FW+3] ^= 1'b1;
                p[i-FW]   ^= 1'b1;
            end
        return p[FW-1:0];
    endfunction

    function automatic logic [FW-1:0] rnd();
        logic [FW-1:0] r;
        for (int i = 0; i < FW; i++) r[i] = 1'($urandom());
        return r;
    endfunction

    task automatic check(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // cycle model, advanced on every active edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_c = '0; m_a = '0; m_left = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 1'b0; m_done = 1'b1; m_c = m_pend;
                end
            end else if (start_i) begin
                m_a = a_i;
                if (cmd_i) begin
                    m_busy = 1'b1; m_left = NDIG; m_pend = ref_mul(a_i, b_i);
                end else begin
                    m_c = b_i ^ c_i; m_done = 1'b1;
                end
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(m_busy ? "R8" : "R3", FW'(done_o), FW'(m_done));
            if (!m_busy) begin
                check(m_done ? cur_tag : "R6", acc_o, m_c);
                check("R5", opa_o, m_a);
            end
        end
        if (cyc > WDOG) begin
            n_bad++;
            $display("FAIL watchdog R3 act=%0d exp<=%0d", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic issue(input logic cmd, input logic [FW-1:0] a, input logic [FW-1:0] b,
                         input logic [FW-1:0] c, input string tag);
        cur_tag = tag;
        start_i = 1'b1; cmd_i = cmd; a_i = a; b_i = b; c_i = c;
        @(negedge clk);
        start_i = 1'b0; a_i = rnd(); b_i = rnd(); c_i = rnd();
    endtask

    task automatic run(input logic cmd, input logic [FW-1:0] a, input logic [FW-1:0] b,
                       input logic [FW-1:0] c, input string tag);
        issue(cmd, a, b, c, tag);
        repeat (cmd ? NDIG + 3 : 3) @(negedge clk);
    endtask

    initial begin
        logic [FW-1:0] v;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9", acc_o, '0);
        check("R9", opa_o, '0);
        check("R9", FW'(done_o), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: additions
        for (int i = 0; i < 3; i++) run(1'b0, rnd(), rnd(), rnd(), "R2");
        // R10: A = 1 lives in the partial final digit
        v = rnd();
        run(1'b1, FW'(1), v, rnd(), "R10");
        // R11: x^162 * x wraps to 0xC9
        run(1'b1, FW'(1) << 162, FW'(2), rnd(), "R11");
        run(1'b1, {FW{1'b1}}, {FW{1'b1}}, '0, "R11");
        // R1: general multiplies
        for (int i = 0; i < 5; i++) run(1'b1, rnd(), rnd(), rnd(), "R1");
        // R4: squares
        for (int i = 0; i < 2; i++) begin
            v = rnd();
            run(1'b1, v, v, rnd(), "R4");
        end
        // R7: stray start during a multiply
        issue(1'b1, rnd(), rnd(), rnd(), "R7");
        repeat (NDIG / 2) @(negedge clk);
        start_i = 1'b1; cmd_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1; cmd_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (NDIG) @(negedge clk);
        // R8: new start in the done cycle
        issue(1'b1, rnd(), rnd(), rnd(), "R8");
        while (!done_o) @(negedge clk);
        issue(1'b0, rnd(), rnd(), rnd(), "R8");
        repeat (2) @(negedge clk);
        issue(1'b1, rnd(), rnd(), rnd(), "R8");
        while (!done_o) @(negedge clk);
        issue(1'b1, rnd(), rnd(), rnd(), "R8");
        repeat (NDIG + 4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule